// File: doc/BRIEF.md
# Oversampled Serial Receiver with Holding Register

This block turns an asynchronous serial line into parallel characters. The line is first passed through a two-flop synchronizer. It is then sampled at sixteen times the bit rate, using a clock enable from a programmable divider. A falling edge arms the start detector, and the start bit is confirmed by a low sample at its mid-point. The receiver then samples each data bit at its centre, least significant bit first, followed by an optional parity bit and the stop bit.

When the first stop bit is sampled, the finished character moves into a holding register. The buffer-full flag, the parity, framing and overrun flags and a one-cycle interrupt pulse all update on that same clock. The shift path is then free to take in the next character while the host reads the held one. A read pulse empties the holding register and clears its flags.

The format is chosen with static inputs: 7 or 8 data bits, parity on or off with an odd or even sense, and 1 or 2 stop bits. These inputs are changed only while the line is idle.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, full_o, ovr_o, par_err_o, frm_err_o and irq_o are 0 and data_o is 0x00.
- R2: With char8_i=1, a frame is received least significant bit first, and data_o holds the 8 data bits with full_o=1.
- R3: With char8_i=0, seven data bits are received into data_o[6:0], and data_o[7] reads 0.
- R4: With par_en_i=1, a parity bit follows the data. It is expected to make the count of ones in data plus parity even (par_odd_i=0) or odd (par_odd_i=1). A mismatch sets par_err_o together with full_o.
- R5: A low sample on the first stop bit sets frm_err_o. The character is still placed in the holding register.
- R6: A character that completes while full_o=1 sets ovr_o and leaves data_o unchanged.
- R7: A one-cycle rd_i pulse while full_o=1 clears full_o, ovr_o, par_err_o and frm_err_o on the next clock.
- R8: irq_o pulses for exactly one cycle each time a character enters the holding register, and never on an overrun.
- R9: A low pulse shorter than half a bit that is high again at the start-bit centre is discarded. No character is produced, and a following valid frame is received normally.
- R10: With stop2_i=1, the receiver waits out a second stop bit, and frames separated by two stop bits are received correctly.
- R11: One bit time is 16*(div_i+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| div_i | input | DIV_W | Oversample divider; one 16x tick every div_i+1 clocks |
| char8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| stop2_i | input | 1 | 1: two stop bits |
| rd_i | input | 1 | Read pulse that empties the holding register |
| data_o | output | 8 | Held character |
| full_o | output | 1 | Holding register full |
| ovr_o | output | 1 | Overrun |
| par_err_o | output | 1 | Parity error |
| frm_err_o | output | 1 | Framing error |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The assertions assume that the format inputs and div_i stay fixed for the whole of a frame. They also assume that rd_i is a single-cycle pulse. The stimulus changes the configuration only during idle gaps of at least two bit times. It drives every bit for exactly 16*(div_i+1) clocks and issues reads as one-cycle pulses between frames. Completions therefore fall at least a full bit time apart, and the one-cycle interrupt rule holds.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR   = 16;
  localparam int CNT_W = $clog2(OSR);
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
  } rx_st_e;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              char8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);

  rx_st_e            st_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [IDX_W-1:0]  bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q, pbit_q;
  logic [IDX_W-1:0]  last_idx;
  logic              at_end;

  assign last_idx = char8_i ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
  assign at_end   = tick_i && (tcnt_q == LAST);
  assign done_o   = at_end && (st_q == ST_STOP);
  assign data_o   = char8_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
  assign perr_o   = par_en_i && (pbit_q != (acc_q ^ par_odd_i));
  assign ferr_o   = ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; tcnt_q <= '0; bidx_q <= '0;
      sh_q <= '0; acc_q <= 1'b0; pbit_q <= 1'b0;
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          tcnt_q <= '0;
          if (!rx_i) st_q <= ST_START;
        end
        ST_START: if (tcnt_q == MID) begin
          // confirm start at bit centre, else false start
          tcnt_q <= '0; bidx_q <= '0; acc_q <= 1'b0;
          st_q   <= rx_i ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (at_end) begin
          sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
          acc_q <= acc_q ^ rx_i;
          if (bidx_q == last_idx) st_q <= par_en_i ? ST_PAR : ST_STOP;
          else                    bidx_q <= bidx_q + 1'b1;
        end
        ST_PAR: if (at_end) begin
          pbit_q <= rx_i;
          st_q   <= ST_STOP;
        end
        ST_STOP: if (at_end) st_q <= stop2_i ? ST_STOP2 : ST_IDLE;
        ST_STOP2: if (at_end) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  stop2_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && stop2_i) |=> (st_q == ST_STOP2));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             char8_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic             rd_i,
  output logic [7:0]       data_o,
  output logic             full_o,
  output logic             ovr_o,
  output logic             par_err_o,
  output logic             frm_err_o,
  output logic             irq_o
);
  localparam int DATA_W = 8;

  logic              tick, rx_s, done, perr, ferr;
  logic [DATA_W-1:0] cdata;

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick));

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s));

  uart_rx_core #(.DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_s),
    .char8_i(char8_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .stop2_i(stop2_i), .done_o(done), .data_o(cdata),
    .perr_o(perr), .ferr_o(ferr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0; full_o <= 1'b0; ovr_o <= 1'b0;
      par_err_o <= 1'b0; frm_err_o <= 1'b0; irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (done) begin
        // a read in the same cycle is taken before the new character
        if (full_o && !rd_i) begin
          ovr_o <= 1'b1;
        end else begin
          data_o    <= cdata;
          par_err_o <= perr;
          frm_err_o <= ferr;
          ovr_o     <= 1'b0;
          full_o    <= 1'b1;
          irq_o     <= 1'b1;
        end
      end else if (rd_i) begin
        full_o <= 1'b0; ovr_o <= 1'b0;
        par_err_o <= 1'b0; frm_err_o <= 1'b0;
      end
    end
  end

  // R8
  irq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o);
  // R6
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(data_o));
  // R7
  flags_need_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o || par_err_o || frm_err_o) |-> full_o);
  // R7
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && full_o && !done) |=> !full_o);
endmodule

// File: tb/uart_rx_dbuf_tb.sv
module uart_rx_dbuf_tb;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, rd = 1'b0;
  logic [7:0] div = 8'd1;
  logic char8 = 1'b1, pen = 1'b0, podd = 1'b0, stop2 = 1'b0;
  logic [7:0] data;
  logic full, ovr, perr, ferr, irq;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  logic [7:0] e_data = 8'h00;
  logic e_full = 0, e_ovr = 0, e_perr = 0, e_ferr = 0;
  int e_irq = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_dbuf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .div_i(div),
    .char8_i(char8), .par_en_i(pen), .par_odd_i(podd), .stop2_i(stop2),
    .rd_i(rd), .data_o(data), .full_o(full), .ovr_o(ovr),
    .par_err_o(perr), .frm_err_o(ferr), .irq_o(irq));

  always @(posedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk(req, "data", data, e_data);
    chk(req, "full", full, e_full);
    chk(req, "ovr", ovr, e_ovr);
    chk(req, "perr", perr, e_perr);
    chk(req, "ferr", ferr, e_ferr);
    chk(req, "irq_count", irq_cnt, e_irq);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (16 * (int'(div) + 1)) @(negedge clk);
  endtask

  // behavioural model of the holding register
  task automatic send(input logic [7:0] d, input bit pbad, input bit sbad);
    int n = char8 ? 8 : 7;
    logic par = podd;
    logic [7:0] m = char8 ? d : {1'b0, d[6:0]};
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      hold_bit(d[i]);
      par ^= d[i];
    end
    if (pen) hold_bit(par ^ pbad);
    hold_bit(~sbad);
    if (stop2) hold_bit(1'b1);
    if (e_full) e_ovr = 1;
    else begin
      e_data = m; e_full = 1; e_ovr = 0;
      e_perr = pen && pbad; e_ferr = sbad; e_irq++;
    end
    hold_bit(1'b1); hold_bit(1'b1);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    e_full = 0; e_ovr = 0; e_perr = 0; e_ferr = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_all("R1");
    chk("R1", "irq", irq, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    send(8'hA5, 0, 0); cmp_all("R2");
    do_read();         cmp_all("R7");
    send(8'h3C, 0, 0); cmp_all("R2");
    do_read();

    char8 = 0;
    send(8'hDA, 0, 0); cmp_all("R3");
    chk("R3", "bit7", data[7], 0);
    do_read(); char8 = 1;

    pen = 1; podd = 0;
    send(8'h71, 0, 0); cmp_all("R4");
    do_read();
    send(8'h71, 1, 0); cmp_all("R4");
    chk("R4", "perr_bad", perr, 1);
    do_read();
    podd = 1;
    send(8'h0F, 0, 0); cmp_all("R4");
    do_read();
    send(8'h0E, 1, 0); cmp_all("R4");
    do_read(); cmp_all("R7");
    pen = 0; podd = 0;

    stop2 = 1;
    send(8'h96, 0, 1); cmp_all("R5");
    chk("R5", "ferr", ferr, 1);
    do_read();
    stop2 = 0;

    send(8'h11, 0, 0);
    send(8'h22, 0, 0); cmp_all("R6");
    chk("R6", "ovr", ovr, 1);
    chk("R8", "no_irq_on_ovr", irq_cnt, 1 + e_irq - 1);
    do_read(); cmp_all("R7");

    rxd = 1'b0;
    repeat (4 * (int'(div) + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    cmp_all("R9");
    send(8'hC3, 0, 0); cmp_all("R9");
    do_read();

    stop2 = 1;
    send(8'h5E, 0, 0); cmp_all("R10");
    do_read();
    send(8'hE7, 0, 0); cmp_all("R10");
    do_read();
    stop2 = 0;

    div = 8'd3;
    repeat (20) @(negedge clk);
    send(8'h4B, 0, 0); cmp_all("R11");
    do_read(); cmp_all("R8");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule